// File: doc/BRIEF.md
# Register-Launched Pitch Copy Engine

This block moves bytes from one memory region to another under the control of a small parameter file. Software writes each parameter by its method index: where to read, where to write, the two line strides, the number of bytes in a line, the number of lines, a remap control word and a 32-bit fill constant. Writing the launch index starts the transfer. No separate start strobe exists.

The engine walks its addresses itself and issues one-byte read and write beats on a valid/ready memory port. It supports three operations. The first is a plain linear copy of one run of bytes. The second is a rectangle copy, in which every line advances its source and destination base by separate strides. The third is a clear, in which a 32-bit constant is written repeatedly and nothing is read. When the final write has been accepted, a one-cycle done strobe is sent to the following semaphore stage. Unsupported remap settings raise a configuration error pulse, and no transfer starts.

Top module: `pitch_copy_engine`

## Requirements
- R1: Register indices are: 0 source offset, 1 destination offset, 2 input pitch, 3 output pitch, 4 line length, 5 line count, 6 remap control, 7 fill constant, 8 launch. A write to any index other than 8 only stores the value. `busy` stays low and no memory beat is issued.
- R2: A write to an index of `NUM_REGS` or above stores nothing. In the following cycle it raises `idx_err` for one cycle.
- R3: A write to index 8 stores the value and starts a transfer. `busy` is high in the cycle after that write.
- R4: When launch bit 0 (multi-line) is 0 and launch bit 1 (remap) is 0, the engine copies line-length bytes from the source offset to the destination offset. The pitches and the line count are ignored.
- R5: When multi-line is 1, the engine copies line-count lines of line-length bytes. Line n is read from source + n·input pitch and written to destination + n·output pitch.
- R6: When remap is 1, multi-line is 0, remap control bits [2:0] equal 4 (constant A) and remap control bits [5:4] equal 3 (4-byte component), the engine writes line-length 32-bit words of the fill constant, least significant byte first, starting at the destination offset. It issues no reads.
- R7: If remap is enabled together with multi-line, or with any other selector or component size, `cfg_err` pulses one cycle after the start. No memory beat is issued and no done strobe follows.
- R8: A launch write that arrives while `busy` is high is ignored. It causes no second transfer and no second done strobe.
- R9: `busy` stays high until the last write is accepted. `done` is a one-cycle pulse in the cycle that follows, with `busy` already low.
- R10: Back-to-back writes to the same index are applied in order, so the last value wins.
- R11: A start with a zero byte count or a zero line count (in multi-line mode) pulses `done` with no memory beat.
- R12: Every beat carries one byte. A request holds its address and data stable until it is accepted. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mth_valid | input | 1 | Parameter write strobe |
| mth_index | input | IDX_W | Method index of the write |
| mth_data | input | DATA_W | Value written |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe to the semaphore stage |
| idx_err | output | 1 | Out-of-range index pulse |
| cfg_err | output | 1 | Unsupported remap configuration pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid, returned in order |
| rd_rsp_data | input | 8 | Read data byte |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 8 | Write data byte |

## Verification
The bench builds the engine with a 12-bit address, an 8-bit length and count width, nine registers and a 5-bit index. The 5-bit index makes indices 9 to 31 reachable, so rejection can be exercised, including indices whose low bits alias the launch and length registers. The 12-bit address lets the bench mirror the whole address space with a byte model and compare every byte after each transfer. Random ready backpressure on both request channels exercises the hold-until-accepted rule and the busy/done timing.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int IX_SRC    = 0;
  localparam int IX_DST    = 1;
  localparam int IX_PIN    = 2;
  localparam int IX_POUT   = 3;
  localparam int IX_LEN    = 4;
  localparam int IX_CNT    = 5;
  localparam int IX_REMAP  = 6;
  localparam int IX_CONST  = 7;
  localparam int IX_LAUNCH = 8;

  localparam logic [2:0] SEL_CONST_A = 3'd4;
  localparam logic [1:0] CSIZE_WORD  = 2'd3;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RREQ  = 2'd1,
    S_RWAIT = 2'd2,
    S_WREQ  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pce_mth_regs.sv
module pce_mth_regs
  import pce_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int IDX_W    = 6,
  parameter int DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             mth_valid,
  input  logic [IDX_W-1:0]                 mth_index,
  input  logic [DATA_W-1:0]                mth_data,
  input  logic                             busy_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  rf_o,
  output logic                             go_o,
  output logic                             idx_err_o
);
  logic in_range;
  logic launch_wr;
  logic go_d, go_q;
  logic err_d, err_q;

  assign in_range  = (32'(mth_index) < NUM_REGS);
  assign launch_wr = mth_valid && in_range && (32'(mth_index) == IX_LAUNCH);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic             wen;
    logic [DATA_W-1:0] val_q;
    assign wen = mth_valid && in_range && (32'(mth_index) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (wen) val_q <= mth_data;
    end
    assign rf_o[g] = val_q;
  end

  always_comb begin
    go_d  = launch_wr && !busy_i && !go_q;
    err_d = mth_valid && !in_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      go_q  <= go_d;
      err_q <= err_d;
    end
  end

  assign go_o      = go_q;
  assign idx_err_o = err_q;

  AST_IDX_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mth_valid && !(32'(mth_index) < NUM_REGS)) |=> idx_err_o) else $error("idx"); // R2
  AST_LAUNCH_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && launch_wr) |=> !go_o) else $error("busy launch"); // R8
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !go_o) else $error("go pulse"); // R3
endmodule

// File: rtl/pce_seq.sv
module pce_seq
  import pce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] src_off_i,
  input  logic [ADDR_W-1:0] dst_off_i,
  input  logic [ADDR_W-1:0] pitch_in_i,
  input  logic [ADDR_W-1:0] pitch_out_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic [LEN_W-1:0]  line_cnt_i,
  input  logic [2:0]        sel_i,
  input  logic [1:0]        csize_i,
  input  logic [DATA_W-1:0] const_i,
  input  logic              multi_i,
  input  logic              remap_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int BYTE_W = LEN_W + 2;

  seq_st_e            st_d, st_q;
  logic [ADDR_W-1:0]  src_d, src_q, dst_d, dst_q;
  logic [ADDR_W-1:0]  pin_d, pin_q, pout_d, pout_q;
  logic [BYTE_W-1:0]  blim_d, blim_q, byte_d, byte_q;
  logic [LEN_W-1:0]   lines_d, lines_q, line_d, line_q;
  logic [DATA_W-1:0]  cval_d, cval_q;
  logic [7:0]         dat_d, dat_q;
  logic               fill_d, fill_q;
  logic               done_d, done_q, err_d, err_q;
  logic [BYTE_W-1:0]  start_bytes;
  logic [LEN_W-1:0]   start_lines;
  logic               bad_remap;

  always_comb begin
    start_bytes = remap_i ? {line_len_i, 2'b00} : BYTE_W'(line_len_i);
    start_lines = multi_i ? line_cnt_i : LEN_W'(1);
    bad_remap   = remap_i && (multi_i || (sel_i != SEL_CONST_A) || (csize_i != CSIZE_WORD));
  end

  always_comb begin
    st_d    = st_q;
    src_d   = src_q;
    dst_d   = dst_q;
    pin_d   = pin_q;
    pout_d  = pout_q;
    blim_d  = blim_q;
    byte_d  = byte_q;
    lines_d = lines_q;
    line_d  = line_q;
    cval_d  = cval_q;
    dat_d   = dat_q;
    fill_d  = fill_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (go_i) begin
          src_d   = src_off_i;
          dst_d   = dst_off_i;
          pin_d   = pitch_in_i;
          pout_d  = pitch_out_i;
          cval_d  = const_i;
          fill_d  = remap_i;
          blim_d  = start_bytes;
          lines_d = start_lines;
          byte_d  = '0;
          line_d  = '0;
          if (bad_remap)                                err_d  = 1'b1;
          else if (start_bytes == '0 || start_lines == '0) done_d = 1'b1;
          else                                           st_d   = remap_i ? S_WREQ : S_RREQ;
        end
      end
      S_RREQ: begin
        if (rd_req_ready) st_d = S_RWAIT;
      end
      S_RWAIT: begin
        if (rd_rsp_valid) begin
          dat_d = rd_rsp_data;
          st_d  = S_WREQ;
        end
      end
      S_WREQ: begin
        if (wr_ready) begin
          if (byte_q == blim_q - BYTE_W'(1)) begin
            byte_d = '0;
            if (line_q == lines_q - LEN_W'(1)) begin
              st_d   = S_IDLE;
              done_d = 1'b1;
            end else begin
              line_d = line_q + LEN_W'(1);
              src_d  = src_q + pin_q;
              dst_d  = dst_q + pout_q;
              st_d   = fill_q ? S_WREQ : S_RREQ;
            end
          end else begin
            byte_d = byte_q + BYTE_W'(1);
            st_d   = fill_q ? S_WREQ : S_RREQ;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      pin_q   <= '0;
      pout_q  <= '0;
      blim_q  <= '0;
      byte_q  <= '0;
      lines_q <= '0;
      line_q  <= '0;
      cval_q  <= '0;
      dat_q   <= '0;
      fill_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      pin_q   <= pin_d;
      pout_q  <= pout_d;
      blim_q  <= blim_d;
      byte_q  <= byte_d;
      lines_q <= lines_d;
      line_q  <= line_d;
      cval_q  <= cval_d;
      dat_q   <= dat_d;
      fill_q  <= fill_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = done_q;
  assign cfg_err_o    = err_q;
  assign rd_req_valid = (st_q == S_RREQ);
  assign rd_req_addr  = src_q + ADDR_W'(byte_q);
  assign wr_valid     = (st_q == S_WREQ);
  assign wr_addr      = dst_q + ADDR_W'(byte_q);
  assign wr_data      = fill_q ? 8'(cval_q >> {byte_q[1:0], 3'b000}) : dat_q;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))) else $error("wr hold"); // R12
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))) else $error("rd hold"); // R12
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid)) else $error("both channels"); // R12
  AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q && busy_o) |-> !rd_req_valid) else $error("fill read"); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o) else $error("done busy"); // R9
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (!busy_o && !done_o)) else $error("err start"); // R7
endmodule

// File: rtl/pitch_copy_engine.sv
module pitch_copy_engine
  import pce_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 9,
  parameter int IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mth_valid,
  input  logic [IDX_W-1:0]  mth_index,
  input  logic [DATA_W-1:0] mth_data,
  output logic              busy,
  output logic              done,
  output logic              idx_err,
  output logic              cfg_err,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic [NUM_REGS-1:0][DATA_W-1:0] rf;
  logic go, seq_busy;
  logic unused_bits;

  assign unused_bits = ^{rf[IX_REMAP][DATA_W-1:6], rf[IX_REMAP][3],
                         rf[IX_LAUNCH][DATA_W-1:2]};

  pce_mth_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .mth_valid (mth_valid),
    .mth_index (mth_index),
    .mth_data  (mth_data),
    .busy_i    (busy),
    .rf_o      (rf),
    .go_o      (go),
    .idx_err_o (idx_err)
  );

  pce_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go),
    .src_off_i    (ADDR_W'(rf[IX_SRC])),
    .dst_off_i    (ADDR_W'(rf[IX_DST])),
    .pitch_in_i   (ADDR_W'(rf[IX_PIN])),
    .pitch_out_i  (ADDR_W'(rf[IX_POUT])),
    .line_len_i   (LEN_W'(rf[IX_LEN])),
    .line_cnt_i   (LEN_W'(rf[IX_CNT])),
    .sel_i        (rf[IX_REMAP][2:0]),
    .csize_i      (rf[IX_REMAP][5:4]),
    .const_i      (rf[IX_CONST]),
    .multi_i      (rf[IX_LAUNCH][0]),
    .remap_i      (rf[IX_LAUNCH][1]),
    .busy_o       (seq_busy),
    .done_o       (done),
    .cfg_err_o    (cfg_err),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data)
  );

  assign busy = go | seq_busy;

  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !cfg_err) |-> busy) else $error("go busy"); // R3
endmodule

// File: tb/test_pitch_copy_engine.sv
module test_pitch_copy_engine;
  localparam int AW = 12;
  localparam int LW = 8;
  localparam int NR = 9;
  localparam int IW = 5;
  localparam int MEM = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mth_valid = 1'b0;
  logic [IW-1:0] mth_index = '0;
  logic [31:0] mth_data = '0;
  logic busy, done, idx_err, cfg_err;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [AW-1:0] rd_req_addr, wr_addr;
  logic [7:0] rd_rsp_data, wr_data;
  logic wr_valid, wr_ready;

  logic [7:0] mem [MEM];
  logic [7:0] exp_mem [MEM];
  logic [15:0] lfsr;
  int wr_cnt, rd_cnt;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pitch_copy_engine #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(32), .NUM_REGS(NR), .IDX_W(IW))
  i_pitch_copy_engine (
    .clk(clk), .rst_n(rst_n), .mth_valid(mth_valid), .mth_index(mth_index), .mth_data(mth_data),
    .busy(busy), .done(done), .idx_err(idx_err), .cfg_err(cfg_err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rd_req_ready = lfsr[0] | lfsr[3];
  assign wr_ready     = lfsr[1] | lfsr[6];

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr         <= 16'hACE1;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= 8'h00;
    end else begin
      lfsr         <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= mem[rd_req_addr];
      if (rd_req_valid && rd_req_ready) rd_cnt = rd_cnt + 1;
      if (wr_valid && wr_ready) begin
        mem[wr_addr] = wr_data;
        wr_cnt = wr_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic prefill(input int seed);
    for (int i = 0; i < MEM; i++) begin
      mem[i]     = 8'(i * 7 + seed);
      exp_mem[i] = 8'(i * 7 + seed);
    end
    wr_cnt = 0;
    rd_cnt = 0;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < MEM; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, longint'(mem[first]), longint'(exp_mem[first]));
  endtask

  task automatic mwr(input int idx, input logic [31:0] val);
    @(negedge clk);
    mth_valid = 1'b1;
    mth_index = IW'(idx);
    mth_data  = val;
    @(negedge clk);
    mth_valid = 1'b0;
  endtask

  // launch, check busy (R3), wait for done, check busy/done timing (R9)
  task automatic launch_wait(input logic [31:0] lval, input int exp_wr, input int exp_rd, input string req);
    bit seen = 0;
    mwr(8, lval);
    chk(busy === 1'b1, "R3 busy after launch", busy, 1);
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
      else if (!busy) begin
        chk(1'b0, "R9 busy dropped before done", 0, 1);
        c = 3000;
      end
    end
    chk(seen, {req, " done seen"}, seen, 1);
    chk(!busy, "R9 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    chk(wr_cnt == exp_wr, {req, " R12 write beats"}, wr_cnt, exp_wr);
    chk(rd_cnt == exp_rd, {req, " R12 read beats"}, rd_cnt, exp_rd);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !idx_err && !cfg_err, "R9 reset idle", {busy, done, idx_err, cfg_err}, 0);
    chk(!rd_req_valid && !wr_valid, "R12 reset no beats", {rd_req_valid, wr_valid}, 0);
  endtask

  task automatic t_params_only();
    prefill(3);
    mwr(0, 32'h100); mwr(1, 32'h400); mwr(2, 32'd32); mwr(3, 32'd48);
    mwr(4, 32'd13);  mwr(5, 32'd3);   mwr(6, 32'h0);   mwr(7, 32'h0);
    repeat (5) @(negedge clk);
    chk(!busy && wr_cnt == 0 && rd_cnt == 0, "R1 no start on param writes", wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_copy1d();
    prefill(11);
    for (int i = 0; i < 13; i++) exp_mem[12'h400 + i] = exp_mem[12'h100 + i];
    launch_wait(32'h0, 13, 13, "R4 1D");
    cmp_mem("R4 1D copy contents");
  endtask

  task automatic t_copy2d();
    prefill(29);
    mwr(0, 32'h200); mwr(1, 32'h800); mwr(2, 32'd32); mwr(3, 32'd20);
    mwr(4, 32'd7);   mwr(5, 32'd5);
    for (int n = 0; n < 5; n++)
      for (int i = 0; i < 7; i++)
        exp_mem[12'h800 + n * 20 + i] = exp_mem[12'h200 + n * 32 + i];
    launch_wait(32'h1, 35, 35, "R5 2D");
    cmp_mem("R5 2D copy contents");
  endtask

  task automatic t_fill();
    logic [31:0] k = 32'hA1B2C3D4;
    prefill(41);
    mwr(1, 32'hA00); mwr(4, 32'd5); mwr(6, 32'h34); mwr(7, k);
    for (int i = 0; i < 20; i++) exp_mem[12'hA00 + i] = 8'(k >> (8 * (i % 4)));
    launch_wait(32'h2, 20, 0, "R6 fill");
    cmp_mem("R6 fill contents");
  endtask

  task automatic t_remap_multi();
    bit err_seen = 0;
    bit done_seen = 0;
    prefill(53);
    mwr(8, 32'h3);
    for (int c = 0; c < 20; c++) begin
      if (cfg_err) err_seen = 1;
      if (done) done_seen = 1;
      @(negedge clk);
    end
    chk(err_seen, "R7 cfg_err raised", err_seen, 1);
    chk(!done_seen && !busy, "R7 no done no busy", {done_seen, busy}, 0);
    chk(wr_cnt == 0 && rd_cnt == 0, "R7 no beats", wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_busy_launch();
    int extra = 0;
    bit seen = 0;
    prefill(67);
    mwr(0, 32'h300); mwr(1, 32'h600); mwr(4, 32'd20); mwr(6, 32'h0);
    for (int i = 0; i < 20; i++) exp_mem[12'h600 + i] = exp_mem[12'h300 + i];
    mwr(8, 32'h0);
    repeat (4) @(negedge clk);
    mwr(8, 32'h0);
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    chk(seen && extra == 0, "R8 single transfer", extra, 0);
    chk(wr_cnt == 20, "R8 write beats", wr_cnt, 20);
    cmp_mem("R8 contents");
  endtask

  task automatic t_bad_index();
    prefill(79);
    mwr(0, 32'h100); mwr(1, 32'h500); mwr(4, 32'd6);
    mwr(20, 32'd99);
    chk(idx_err === 1'b1, "R2 idx_err after index 20", idx_err, 1);
    @(negedge clk);
    chk(idx_err === 1'b0, "R2 idx_err one cycle", idx_err, 0);
    mwr(24, 32'h0);
    chk(idx_err === 1'b1 && !busy, "R2 index 24 no launch", {idx_err, busy}, 2'b10);
    for (int i = 0; i < 6; i++) exp_mem[12'h500 + i] = exp_mem[12'h100 + i];
    launch_wait(32'h0, 6, 6, "R2 length kept");
    cmp_mem("R2 contents");
  endtask

  task automatic t_burst();
    prefill(91);
    mwr(0, 32'h140); mwr(1, 32'h700);
    @(negedge clk);
    mth_valid = 1'b1; mth_index = 5'd4; mth_data = 32'd40;
    @(negedge clk); mth_data = 32'd2;
    @(negedge clk); mth_data = 32'd6;
    @(negedge clk); mth_valid = 1'b0;
    for (int i = 0; i < 6; i++) exp_mem[12'h700 + i] = exp_mem[12'h140 + i];
    launch_wait(32'h0, 6, 6, "R10 burst");
    cmp_mem("R10 contents");
  endtask

  task automatic t_zero();
    prefill(103);
    mwr(4, 32'd0);
    launch_wait(32'h0, 0, 0, "R11 zero len");
    mwr(4, 32'd4); mwr(5, 32'd0);
    launch_wait(32'h1, 0, 0, "R11 zero lines");
    cmp_mem("R11 memory untouched");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wr_cnt = 0;
    rd_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_params_only();
    t_copy1d();
    t_copy2d();
    t_fill();
    t_remap_multi();
    t_busy_launch();
    t_bad_index();
    t_burst();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule